// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave side of the serial command port of a flash memory. A host frames each command by pulling the active-low select low. It then shifts an 8-bit opcode, and any address or payload, into the data input most significant bit first. The block samples on rising serial-clock edges and updates its serial output on falling edges, so it works with the clock idling either low or high. The serial input and clock are oversampled by the system clock through a two-stage synchronizer.

Two jobs are handled here. The first is an identification read. The opcode is followed by a 24-bit address, and the serial output then drives a stream of identification bytes: a vendor byte and a capacity byte, which alternate for as long as the host keeps clocking. The lowest address bit picks which byte comes first. The second job is a write-enable latch, set and cleared by dedicated one-byte commands. Page program, sector erase, chip erase and status-write commands only produce a one-cycle grant strobe toward the back end when the latch is set and the frame has the correct length. An accepted command clears the latch again. The pad driver uses the output data together with its enable.

Top module: `sfc_cmd_frontend`

## Requirements
- R1: After reset the write-enable latch output is 0, the serial output enable is 0 and all four grant strobes are 0.
- R2: A frame of exactly 8 bits carrying the set opcode (default 06h) sets the latch once the select goes high.
- R3: A frame of exactly 8 bits carrying the clear opcode (default 04h) clears the latch once the select goes high.
- R4: A frame in which the select rises before 8 bits have been clocked changes nothing, whatever bits were sent.
- R5: For the identification opcode (default 90h), the output enable stays 0 during the 32 opcode and address bits. When the lowest address bit is 0, the bytes that follow are the vendor ID, then the device ID, then alternating, each sent most significant bit first. Address bits 23..1 are ignored.
- R6: When the lowest address bit is 1, the stream starts with the device ID byte (a parameter) and then alternates.
- R7: Output data changes only on falling serial-clock edges. The first data bit is driven on the falling edge that follows the 32nd rising edge, and the host samples it on the next rising edge. Both clock idle levels work.
- R8: With the latch set, a grant strobe lasting one system clock is issued after the select rises for: chip erase (C7h) of exactly 8 bits, status write (01h) of exactly 16 bits, sector erase (D8h) of exactly 32 bits, and page program (02h) of 40 or more bits that form a whole number of bytes.
- R9: An accepted grant clears the latch in the same cycle the strobe appears.
- R10: A program, erase or status-write frame with the latch at 0 produces no grant.
- R11: An unrecognised opcode never enables the serial output during its frame.
- R12: A command of the wrong length produces no grant and leaves the latch unchanged. This covers a set or clear opcode of more than 8 bits, and a program or erase of a wrong bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial port |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock from host |
| si | input | 1 | Serial data from host |
| so_data | output | 1 | Serial output data toward the pad |
| so_oe | output | 1 | Output enable of the serial pad; 0 means high impedance |
| wel | output | 1 | Write-enable latch state |
| pp_grant | output | 1 | One-cycle page program permit |
| se_grant | output | 1 | One-cycle sector erase permit |
| be_grant | output | 1 | One-cycle chip erase permit |
| wrsr_grant | output | 1 | One-cycle status-write permit |

## Verification
The hardest situation to reach is a frame that is almost right: the latch is set and the opcode is valid, but the bit count is off by a few bits. Only the length rule stops the grant in that case, and the latch must then survive for the next command. The stimulus sets the latch and then sends page program and sector erase frames of 36 and 24 bits. It then follows with a correctly sized command, so that a latch that was wrongly cleared shows up as a missing grant. Identification reads are run with both clock idle levels and with high address bits set, and a monitor collects the returned bytes against a queue of expected ones.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t OPC_SET_DEF   = 8'h06;
  localparam byte_t OPC_CLR_DEF   = 8'h04;
  localparam byte_t OPC_IDRD_DEF  = 8'h90;
  localparam byte_t OPC_PROG_DEF  = 8'h02;
  localparam byte_t OPC_SERA_DEF  = 8'hD8;
  localparam byte_t OPC_CERA_DEF  = 8'hC7;
  localparam byte_t OPC_WSTAT_DEF = 8'h01;
endpackage

// File: rtl/sfc_sync_edge.sv
module sfc_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic cs_rise,
  output logic si_s
);
  logic sck_s, sck_d, cs_s, cs_d, si_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= 1'b0;
      sck_d <= 1'b0;
      cs_s  <= 1'b1;
      cs_d  <= 1'b1;
      si_q  <= 1'b0;
    end else begin
      sck_s <= sck;
      sck_d <= sck_s;
      cs_s  <= cs_n;
      cs_d  <= cs_s;
      si_q  <= si;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_act   = ~cs_s;
  assign cs_rise  = cs_s & ~cs_d;
  assign si_s     = si_q;
endmodule

// File: rtl/sfc_cmd_shift.sv
module sfc_cmd_shift
  import sfc_pkg::*;
#(
  parameter int    CNT_W    = 12,
  parameter byte_t OPC_IDRD = OPC_IDRD_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_act,
  input  logic             sck_rise,
  input  logic             si_s,
  output byte_t            opc,
  output logic             opc_vld,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             id_start,
  output logic             addr_lsb
);
  localparam logic [CNT_W-1:0] LAST_OPC  = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(31);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [6:0]       pre_q, pre_n;
  byte_t            opc_q, opc_n;
  logic             vld_q, vld_n;
  logic             start_q, start_n;
  logic             lsb_q, lsb_n;

  always_comb begin
    cnt_n   = cnt_q;
    pre_n   = pre_q;
    opc_n   = opc_q;
    vld_n   = vld_q;
    lsb_n   = lsb_q;
    start_n = 1'b0;
    if (!cs_act) begin
      cnt_n = '0;
      vld_n = 1'b0;
    end else if (sck_rise) begin
      if (cnt_q != CNT_MAX) cnt_n = cnt_q + CNT_W'(1);
      pre_n = {pre_q[5:0], si_s};
      if (cnt_q == LAST_OPC) begin
        opc_n = {pre_q, si_s};
        vld_n = 1'b1;
      end
      if (cnt_q == LAST_ADDR && vld_q && opc_q == OPC_IDRD) begin
        start_n = 1'b1;
        lsb_n   = si_s;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pre_q   <= '0;
      opc_q   <= '0;
      vld_q   <= 1'b0;
      start_q <= 1'b0;
      lsb_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      pre_q   <= pre_n;
      opc_q   <= opc_n;
      vld_q   <= vld_n;
      start_q <= start_n;
      lsb_q   <= lsb_n;
    end
  end

  assign opc      = opc_q;
  assign opc_vld  = vld_q;
  assign bit_cnt  = cnt_q;
  assign id_start = start_q;
  assign addr_lsb = lsb_q;

  // R4: an opcode is only ever marked valid once 8 bits have arrived
  p_opc_full_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (cnt_q >= CNT_W'(8)));
endmodule

// File: rtl/sfc_id_tx.sv
module sfc_id_tx
  import sfc_pkg::*;
#(
  parameter byte_t MFR_ID = 8'h01,
  parameter byte_t DEV_ID = 8'h12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_act,
  input  logic sck_fall,
  input  logic id_start,
  input  logic addr_lsb,
  output logic so_data,
  output logic so_oe
);
  logic       armed_q, armed_n;
  logic       oe_q, oe_n;
  logic       sel_q, sel_n;
  byte_t      txb_q, txb_n;
  logic [2:0] idx_q, idx_n;

  always_comb begin
    armed_n = armed_q;
    oe_n    = oe_q;
    sel_n   = sel_q;
    txb_n   = txb_q;
    idx_n   = idx_q;
    if (!cs_act) begin
      armed_n = 1'b0;
      oe_n    = 1'b0;
    end else begin
      if (id_start) begin
        armed_n = 1'b1;
        sel_n   = addr_lsb;
      end
      if (sck_fall && armed_q) begin
        if (!oe_q) begin
          oe_n  = 1'b1;
          txb_n = sel_q ? DEV_ID : MFR_ID;
          idx_n = 3'd0;
        end else if (idx_q == 3'd7) begin
          sel_n = ~sel_q;
          txb_n = sel_q ? MFR_ID : DEV_ID;
          idx_n = 3'd0;
        end else begin
          txb_n = {txb_q[6:0], 1'b0};
          idx_n = idx_q + 3'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      oe_q    <= 1'b0;
      sel_q   <= 1'b0;
      txb_q   <= '0;
      idx_q   <= '0;
    end else begin
      armed_q <= armed_n;
      oe_q    <= oe_n;
      sel_q   <= sel_n;
      txb_q   <= txb_n;
      idx_q   <= idx_n;
    end
  end

  assign so_oe   = oe_q;
  assign so_data = oe_q & txb_q[7];

  // R11: the pad is released one cycle after the frame ends at the latest
  p_release_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && $past(!cs_act)) |-> !oe_q);
  // R7: a driven bit only moves after a falling serial clock edge
  p_bit_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && $past(oe_q) && (txb_q[7] != $past(txb_q[7]))) |-> $past(sck_fall));
endmodule

// File: rtl/sfc_wel_ctrl.sv
module sfc_wel_ctrl
  import sfc_pkg::*;
#(
  parameter int    CNT_W     = 12,
  parameter byte_t OPC_SET   = OPC_SET_DEF,
  parameter byte_t OPC_CLR   = OPC_CLR_DEF,
  parameter byte_t OPC_PROG  = OPC_PROG_DEF,
  parameter byte_t OPC_SERA  = OPC_SERA_DEF,
  parameter byte_t OPC_CERA  = OPC_CERA_DEF,
  parameter byte_t OPC_WSTAT = OPC_WSTAT_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_rise,
  input  byte_t            opc,
  input  logic             opc_vld,
  input  logic [CNT_W-1:0] bit_cnt,
  output logic             wel,
  output logic             pp_grant,
  output logic             se_grant,
  output logic             be_grant,
  output logic             wrsr_grant
);
  localparam logic [CNT_W-1:0] LEN_OP   = CNT_W'(8);
  localparam logic [CNT_W-1:0] LEN_STAT = CNT_W'(16);
  localparam logic [CNT_W-1:0] LEN_ADR  = CNT_W'(32);
  localparam logic [CNT_W-1:0] LEN_PMIN = CNT_W'(40);

  logic wel_q, wel_n;
  logic pp_q, se_q, be_q, ws_q;
  logic pp_n, se_n, be_n, ws_n;
  logic done, len_pp;

  always_comb begin
    done   = cs_rise && opc_vld;
    len_pp = (bit_cnt >= LEN_PMIN) && (bit_cnt[2:0] == 3'b000);
    pp_n   = done && wel_q && opc == OPC_PROG  && len_pp;
    se_n   = done && wel_q && opc == OPC_SERA  && bit_cnt == LEN_ADR;
    be_n   = done && wel_q && opc == OPC_CERA  && bit_cnt == LEN_OP;
    ws_n   = done && wel_q && opc == OPC_WSTAT && bit_cnt == LEN_STAT;
    wel_n  = wel_q;
    if (done && bit_cnt == LEN_OP && opc == OPC_SET) wel_n = 1'b1;
    if (done && bit_cnt == LEN_OP && opc == OPC_CLR) wel_n = 1'b0;
    if (pp_n || se_n || be_n || ws_n)                wel_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
      pp_q  <= 1'b0;
      se_q  <= 1'b0;
      be_q  <= 1'b0;
      ws_q  <= 1'b0;
    end else begin
      wel_q <= wel_n;
      pp_q  <= pp_n;
      se_q  <= se_n;
      be_q  <= be_n;
      ws_q  <= ws_n;
    end
  end

  assign wel        = wel_q;
  assign pp_grant   = pp_q;
  assign se_grant   = se_q;
  assign be_grant   = be_q;
  assign wrsr_grant = ws_q;

  // R10: a grant needs the latch set before it
  p_grant_needs_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_q || se_q || be_q || ws_q) |-> $past(wel_q));
  // R9: a grant leaves the latch cleared
  p_grant_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_q || se_q || be_q || ws_q) |-> !wel_q);
  // R8: at most one grant at a time
  p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pp_q, se_q, be_q, ws_q}));
  // R4: the latch moves only at the end of a frame
  p_latch_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wel_q) |-> $past(cs_rise));
endmodule

// File: rtl/sfc_cmd_frontend.sv
module sfc_cmd_frontend
  import sfc_pkg::*;
#(
  parameter int    CNT_W     = 12,
  parameter byte_t MFR_ID    = 8'h01,
  parameter byte_t DEV_ID    = 8'h12,
  parameter byte_t OPC_SET   = OPC_SET_DEF,
  parameter byte_t OPC_CLR   = OPC_CLR_DEF,
  parameter byte_t OPC_IDRD  = OPC_IDRD_DEF,
  parameter byte_t OPC_PROG  = OPC_PROG_DEF,
  parameter byte_t OPC_SERA  = OPC_SERA_DEF,
  parameter byte_t OPC_CERA  = OPC_CERA_DEF,
  parameter byte_t OPC_WSTAT = OPC_WSTAT_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so_data,
  output logic so_oe,
  output logic wel,
  output logic pp_grant,
  output logic se_grant,
  output logic be_grant,
  output logic wrsr_grant
);
  logic             sck_rise, sck_fall, cs_act, cs_rise, si_s;
  byte_t            opc;
  logic             opc_vld, id_start, addr_lsb;
  logic [CNT_W-1:0] bit_cnt;

  sfc_sync_edge u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act),
    .cs_rise(cs_rise), .si_s(si_s)
  );

  sfc_cmd_shift #(.CNT_W(CNT_W), .OPC_IDRD(OPC_IDRD)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise),
    .si_s(si_s), .opc(opc), .opc_vld(opc_vld), .bit_cnt(bit_cnt),
    .id_start(id_start), .addr_lsb(addr_lsb)
  );

  sfc_id_tx #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_idtx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_fall(sck_fall),
    .id_start(id_start), .addr_lsb(addr_lsb),
    .so_data(so_data), .so_oe(so_oe)
  );

  sfc_wel_ctrl #(
    .CNT_W(CNT_W), .OPC_SET(OPC_SET), .OPC_CLR(OPC_CLR),
    .OPC_PROG(OPC_PROG), .OPC_SERA(OPC_SERA), .OPC_CERA(OPC_CERA),
    .OPC_WSTAT(OPC_WSTAT)
  ) u_wel (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .opc(opc),
    .opc_vld(opc_vld), .bit_cnt(bit_cnt), .wel(wel),
    .pp_grant(pp_grant), .se_grant(se_grant), .be_grant(be_grant),
    .wrsr_grant(wrsr_grant)
  );
endmodule

// File: tb/sfc_cmd_frontend_tb_top.sv
module sfc_cmd_frontend_tb_top;
  localparam logic [7:0] TB_MFR = 8'h01;
  localparam logic [7:0] TB_DEV = 8'h26;

  logic clk, rst_n, cs_n, sck, si;
  logic so_data, so_oe, wel, pp_grant, se_grant, be_grant, wrsr_grant;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_bytes[$];
  int         exp_grants[$];   // 1 program, 2 sector, 3 chip, 4 status
  bit         oe_seen;

  sfc_cmd_frontend #(.MFR_ID(TB_MFR), .DEV_ID(TB_DEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .so_data(so_data), .so_oe(so_oe), .wel(wel), .pp_grant(pp_grant),
    .se_grant(se_grant), .be_grant(be_grant), .wrsr_grant(wrsr_grant)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_frame(bit m3);
    sck = m3;
    wait_clk(2);
    cs_n = 1'b0;
    oe_seen = 1'b0;
    wait_clk(4);
  endtask

  task automatic shift_bit(bit b);
    sck = 1'b0; si = b; wait_clk(4);
    sck = 1'b1; wait_clk(4);
  endtask

  task automatic close_frame(bit m3);
    if (!m3) sck = 1'b0;
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic send_cmd(logic [7:0] op, int nbits, bit m3);
    open_frame(m3);
    for (int i = 0; i < nbits; i++) shift_bit(i < 8 ? op[7 - i] : 1'b0);
    close_frame(m3);
  endtask

  task automatic expect_grant(int code, string req);
    exp_grants.push_back(code);
  endtask

  task automatic grants_drained(string req);
    check(exp_grants.size() == 0, req, exp_grants.size(), 0);
    exp_grants.delete();
  endtask

  task automatic read_id(logic [23:0] addr, int nbytes, bit m3, string req);
    bit first;
    first = addr[0];
    for (int k = 0; k < nbytes; k++) begin
      exp_bytes.push_back(first ? TB_DEV : TB_MFR);
      first = ~first;
    end
    open_frame(m3);
    for (int i = 0; i < 8; i++)  shift_bit(8'h90 >> (7 - i));
    for (int i = 0; i < 24; i++) shift_bit(addr[23 - i]);
    check(!oe_seen, {req, " hi-Z during opcode and address"}, oe_seen, 0);
    for (int i = 0; i < nbytes * 8; i++) shift_bit(1'b0);
    close_frame(m3);
    check(exp_bytes.size() == 0, {req, " all bytes returned"}, exp_bytes.size(), 0);
    exp_bytes.delete();
  endtask

  always @(negedge clk) if (so_oe) oe_seen = 1'b1;

  // monitor: ID bytes as the host would sample them
  initial begin
    automatic int nb = 0;
    automatic logic [7:0] sh = '0;
    forever begin
      @(posedge sck or posedge cs_n);
      if (cs_n) nb = 0;
      else if (so_oe) begin
        sh = {sh[6:0], so_data};
        nb++;
        if (nb == 8) begin
          nb = 0;
          if (exp_bytes.size() == 0) check(1'b0, "R5 unexpected ID byte", sh, 0);
          else begin
            automatic logic [7:0] e = exp_bytes.pop_front();
            check(sh == e, "R5/R6/R7 ID byte", sh, e);
          end
        end
      end
    end
  end

  // monitor: grant strobes
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (pp_grant | se_grant | be_grant | wrsr_grant)) begin
        automatic int code = pp_grant ? 1 : se_grant ? 2 : be_grant ? 3 : 4;
        if (exp_grants.size() == 0) check(1'b0, "R10/R12 unexpected grant", code, 0);
        else begin
          automatic int e = exp_grants.pop_front();
          check(code == e, "R8 grant kind", code, e);
          check(wel == 1'b0, "R9 latch cleared with grant", wel, 0);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    // R1
    check(wel == 1'b0, "R1 latch after reset", wel, 0);
    check(so_oe == 1'b0, "R1 oe after reset", so_oe, 0);
    check({pp_grant, se_grant, be_grant, wrsr_grant} == 4'b0, "R1 grants after reset",
          {pp_grant, se_grant, be_grant, wrsr_grant}, 0);

    send_cmd(8'h06, 8, 1'b0);
    check(wel == 1'b1, "R2 set latch", wel, 1);
    send_cmd(8'h04, 8, 1'b1);
    check(wel == 1'b0, "R3 clear latch", wel, 0);
    send_cmd(8'h06, 5, 1'b0);
    check(wel == 1'b0, "R4 truncated set ignored", wel, 0);
    send_cmd(8'h06, 8, 1'b1);
    send_cmd(8'h04, 7, 1'b0);
    check(wel == 1'b1, "R4 truncated clear ignored", wel, 1);
    send_cmd(8'h04, 16, 1'b0);
    check(wel == 1'b1, "R12 overlong clear ignored", wel, 1);

    expect_grant(3, "R8");
    send_cmd(8'hC7, 8, 1'b0);
    grants_drained("R8 chip erase grant");
    check(wel == 1'b0, "R9 latch after chip erase", wel, 0);
    send_cmd(8'hC7, 8, 1'b0);
    send_cmd(8'h02, 48, 1'b0);
    grants_drained("R10 no grant with latch clear");

    send_cmd(8'h06, 8, 1'b0);
    expect_grant(2, "R8");
    send_cmd(8'hD8, 32, 1'b1);
    grants_drained("R8 sector erase grant");
    send_cmd(8'h06, 8, 1'b0);
    expect_grant(4, "R8");
    send_cmd(8'h01, 16, 1'b0);
    grants_drained("R8 status write grant");

    send_cmd(8'h06, 8, 1'b0);
    send_cmd(8'h02, 36, 1'b0);
    send_cmd(8'hD8, 24, 1'b0);
    send_cmd(8'hC7, 9, 1'b0);
    check(wel == 1'b1, "R12 wrong lengths keep latch", wel, 1);
    expect_grant(1, "R8");
    send_cmd(8'h02, 48, 1'b0);
    grants_drained("R12 grant after near-miss frames");
    check(wel == 1'b0, "R9 latch after program", wel, 0);

    read_id(24'h000000, 4, 1'b0, "R5 addr 0 mode0");
    read_id(24'h000001, 3, 1'b1, "R6 addr 1 mode3");
    read_id(24'hFFFFFE, 2, 1'b1, "R5 high addr bits ignored");

    send_cmd(8'hAB, 48, 1'b0);
    check(!oe_seen, "R11 unknown opcode keeps hi-Z", oe_seen, 0);
    grants_drained("R11 no grant from reads or unknown");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule